// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block copies a programmed number of items from one memory region to another over a simple 32-bit bus. Each item is a byte, a half-word or a word, selected by a two-bit width code. Software loads a source base, a destination base and an item count. It then writes the control word with the start bit set. For each item the engine issues a bus read, holds the returned item, and issues a bus write. The next item begins only after the write has been accepted.

The source pointer can be held constant, so that one source location fills a whole destination range. Either pointer can be made to walk downward. When a pointer walks downward, the alignment check on that pointer is waived. The engine checks the source and destination bases against the selected width. It reports any misalignment in read-only status bits, and it refuses to start while either flag is set. An optional lock output stays high for the whole run. A done flag, which doubles as the interrupt, stays pending until software clears it.

Register access uses a single-cycle write strobe with a word index and a combinational read port. Index 0 is the control word, index 1 the source base, index 2 the destination base, index 3 the item count and index 4 the status word.

Top module: `dma_mover`

## Requirements
- R1: Width code bits [2:1] of control select the item size: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. Each pointer steps by that size. Code 11 is refused at start: status bit 1 is set and no bus cycle occurs.
- R2: Status bit 2 reads 1 when the source base is misaligned for the programmed width (word: low two bits not 00; half-word: bit 0 set; byte: never). It reads 0 otherwise, and always 0 while control bit 5 (source descending) is set.
- R3: Status bit 3 applies the same rule to the destination base, waived while control bit 6 (destination descending) is set.
- R4: A start with either alignment flag set (evaluated with the width and direction bits of that same write) is refused. Status bit 1 (error, write 1 to clear) is set and no bus request is made.
- R5: Control bit 0 (start) reads 1 while a transfer runs and is cleared by the engine when the last item is written. Status bit 4 reads 1 while running.
- R6: The start bit is honoured only when control bits [8:7] are 00 (memory to memory) or 01 (memory to I/O). Codes 10 and 11 ignore it: no run, no error, and the start bit reads 0.
- R7: With control bit 3 set, every read of the run uses the source base address. With it clear, the source pointer moves by one item after each item.
- R8: With control bit 4 set, lock_o is high from the first to the last bus request of the run. With it clear, lock_o stays low.
- R9: Each item is one read followed by one write. The item is taken from byte lane src[1:0] of rd_data and placed at byte lane dst[1:0] of wr_data, with wr_strb marking exactly its bytes. Request address and data stay stable until granted.
- R10: After the item count has been written, the engine returns to idle and sets status bit 0 (done, write 1 to clear). irq_o equals that bit.
- R11: Control bits 5 and 6 make the source and the destination pointer, respectively, walk downward by one item per item.
- R12: Writes to the control, source, destination and count registers are ignored while a transfer runs.
- R13: A start with a count of 0 makes no bus request and sets done at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| rd_req | output | 1 | Bus read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_gnt | input | 1 | Read accepted; rd_data valid this cycle |
| rd_data | input | 32 | Read data word |
| wr_req | output | 1 | Bus write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Write data, lane-steered |
| wr_strb | output | 4 | Byte enables of the write |
| wr_gnt | input | 1 | Write accepted |
| lock_o | output | 1 | Bus lock held during a locked run |
| irq_o | output | 1 | Pending completion interrupt |

## Verification
The assertions check the following on every cycle: read-before-write ordering, stability of a stalled write, a constant source address while the source is held, aligned word reads, an unbroken lock for the length of a run, and done with a cleared start bit at the end of every run. The bench scenarios are the only place that show the copied bytes landing in the right lanes and addresses for each width and direction. They also show that misaligned or reserved-width starts are refused without any bus traffic, that hardware modes ignore start, and that writes during a run leave the registers unchanged.

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_gnt,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb,
  input  logic              wr_gnt,
  output logic              lock_o,
  output logic              irq_o
);

  localparam logic [2:0] IX_CTRL = 3'd0;
  localparam logic [2:0] IX_SRC  = 3'd1;
  localparam logic [2:0] IX_DST  = 3'd2;
  localparam logic [2:0] IX_CNT  = 3'd3;
  localparam logic [2:0] IX_STAT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t state;

  logic       c_go, c_hold, c_lock, c_sdesc, c_ddesc;
  logic [1:0] c_width, c_mode;
  logic [ADDR_W-1:0] src_base, dst_base, src_cur, dst_cur, step;
  logic [CNT_W-1:0]  cnt_base, left;
  logic [31:0] item;
  logic st_done, st_err;

  function automatic logic misaligned(input logic [1:0] w, input logic desc, input logic [1:0] lo);
    return !desc && ((w == 2'b10 && lo != 2'b00) || (w == 2'b01 && lo[0]));
  endfunction

  function automatic logic [ADDR_W-1:0] size_of(input logic [1:0] w);
    case (w)
      2'b00:   return ADDR_W'(1);
      2'b01:   return ADDR_W'(2);
      default: return ADDR_W'(4);
    endcase
  endfunction

  logic busy, src_mis, dst_mis, wr_ctrl, go_req, go_mode, go_fit, go_ok, go_bad, last_wr;
  logic [1:0] n_width;
  logic [3:0] mask;

  assign busy    = (state != S_IDLE);
  assign src_mis = misaligned(c_width, c_sdesc, src_base[1:0]);
  assign dst_mis = misaligned(c_width, c_ddesc, dst_base[1:0]);

  assign n_width = cfg_wdata[2:1];
  assign wr_ctrl = cfg_we && cfg_addr == IX_CTRL && !busy;
  assign go_req  = wr_ctrl && cfg_wdata[0];
  assign go_mode = !cfg_wdata[8];
  assign go_fit  = n_width != 2'b11
                && !misaligned(n_width, cfg_wdata[5], src_base[1:0])
                && !misaligned(n_width, cfg_wdata[6], dst_base[1:0]);
  assign go_ok   = go_req && go_mode && go_fit;
  assign go_bad  = go_req && go_mode && !go_fit;
  assign last_wr = (state == S_WRITE) && wr_gnt && left == CNT_W'(1);
  assign step    = size_of(c_width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      c_go     <= 1'b0;
      c_hold   <= 1'b0;
      c_lock   <= 1'b0;
      c_sdesc  <= 1'b0;
      c_ddesc  <= 1'b0;
      c_width  <= 2'b00;
      c_mode   <= 2'b00;
      src_base <= '0;
      dst_base <= '0;
      cnt_base <= '0;
      src_cur  <= '0;
      dst_cur  <= '0;
      left     <= '0;
      item     <= '0;
      st_done  <= 1'b0;
      st_err   <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == IX_STAT) begin
        st_done <= st_done & ~cfg_wdata[0];
        st_err  <= st_err  & ~cfg_wdata[1];
      end
      if (!busy && cfg_we) begin
        case (cfg_addr)
          IX_SRC: src_base <= cfg_wdata[ADDR_W-1:0];
          IX_DST: dst_base <= cfg_wdata[ADDR_W-1:0];
          IX_CNT: cnt_base <= cfg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (wr_ctrl) begin
        c_width <= n_width;
        c_hold  <= cfg_wdata[3];
        c_lock  <= cfg_wdata[4];
        c_sdesc <= cfg_wdata[5];
        c_ddesc <= cfg_wdata[6];
        c_mode  <= cfg_wdata[8:7];
        c_go    <= go_ok && cnt_base != '0;
      end
      if (go_bad) st_err <= 1'b1;
      if (go_ok) begin
        if (cnt_base == '0) begin
          st_done <= 1'b1;
        end else begin
          state   <= S_READ;
          src_cur <= src_base;
          dst_cur <= dst_base;
          left    <= cnt_base;
        end
      end
      case (state)
        S_READ: if (rd_gnt) begin
          item  <= rd_data >> {src_cur[1:0], 3'b000};
          state <= S_WRITE;
        end
        S_WRITE: if (wr_gnt) begin
          if (!c_hold) src_cur <= c_sdesc ? src_cur - step : src_cur + step;
          dst_cur <= c_ddesc ? dst_cur - step : dst_cur + step;
          left    <= left - CNT_W'(1);
          if (last_wr) begin
            state   <= S_IDLE;
            c_go    <= 1'b0;
            st_done <= 1'b1;
          end else begin
            state <= S_READ;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (c_width)
      2'b00:   mask = 4'b0001;
      2'b01:   mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
  end

  assign rd_req  = (state == S_READ);
  assign rd_addr = src_cur;
  assign wr_req  = (state == S_WRITE);
  assign wr_addr = dst_cur;
  assign wr_data = item << {dst_cur[1:0], 3'b000};
  assign wr_strb = mask << dst_cur[1:0];
  assign lock_o  = busy && c_lock;
  assign irq_o   = st_done;

  always_comb begin
    case (cfg_addr)
      IX_CTRL: cfg_rdata = {23'b0, c_mode, c_ddesc, c_sdesc, c_lock, c_hold, c_width, c_go};
      IX_SRC:  cfg_rdata = 32'(src_base);
      IX_DST:  cfg_rdata = 32'(dst_base);
      IX_CNT:  cfg_rdata = 32'(cnt_base);
      IX_STAT: cfg_rdata = {27'b0, busy, dst_mis, src_mis, st_err, st_done};
      default: cfg_rdata = 32'b0;
    endcase
  end

  a_r9_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_req && rd_gnt));

  a_r9_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_gnt |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb));

  a_r7_source_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy && c_hold |=> !busy || $stable(rd_addr));

  a_r1_word_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && c_width == 2'b10 && !c_sdesc |-> rd_addr[1:0] == 2'b00);

  a_r8_lock_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
    busy && lock_o |=> lock_o || !busy);

  a_r5_start_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !c_go && st_done);

  a_r4_no_run_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
    go_bad |=> !busy && st_err);

endmodule

// File: tb/dma_mover_test.sv
module dma_mover_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic rd_req, wr_req, rd_gnt, wr_gnt, lock_o, irq_o;
  logic [31:0] rd_addr, wr_addr, rd_data, wr_data;
  logic [3:0] wr_strb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mover uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb), .wr_gnt(wr_gnt),
    .lock_o(lock_o), .irq_o(irq_o)
  );

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] lfsr = 8'hB5;
  logic fill = 1'b0;
  logic [7:0] seed = 8'd0;
  logic [7:0] ra, wa;

  function automatic logic [7:0] pat(input int i, input logic [7:0] s);
    return 8'(i * 7 + s * 13 + 1);
  endfunction

  assign ra = {rd_addr[7:2], 2'b00};
  assign wa = {wr_addr[7:2], 2'b00};
  assign rd_data = {mem[8'(ra + 8'd3)], mem[8'(ra + 8'd2)], mem[8'(ra + 8'd1)], mem[ra]};
  assign rd_gnt = rd_req & lfsr[0];
  assign wr_gnt = wr_req & lfsr[1];

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (fill) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
    end else if (wr_req && wr_gnt) begin
      for (int b = 0; b < 4; b++)
        if (wr_strb[b]) mem[8'(wa + 8'(b))] <= wr_data[8*b +: 8];
    end
  end

  int req_cnt = 0, lock_bad = 0, order_bad = 0;
  logic pend = 1'b0, exp_lock = 1'b0;

  always @(negedge clk) begin
    if (rd_req || wr_req) begin
      req_cnt++;
      if (lock_o !== exp_lock) lock_bad++;
    end
    if (rd_req && rd_gnt) begin
      if (pend) order_bad++;
      pend = 1'b1;
    end
    if (wr_req && wr_gnt) begin
      if (!pend) order_bad++;
      pend = 1'b0;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic fill_mem(input logic [7:0] s);
    @(negedge clk);
    seed = s; fill = 1'b1;
    @(negedge clk);
    fill = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i, s);
  endtask

  // {ctrl[11:0], src[7:0], dst[7:0], count[7:0]}
  localparam logic [35:0] VEC [6] = '{
    {12'h015, 8'h00, 8'h80, 8'd4},
    {12'h003, 8'h12, 8'h42, 8'd5},
    {12'h009, 8'h21, 8'h63, 8'd7},
    {12'h00D, 8'h40, 8'hC0, 8'd3},
    {12'h0B1, 8'h3F, 8'hA0, 8'd6},
    {12'h043, 8'h50, 8'hE6, 8'd4}
  };

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_reg(3'd4, r); chk(r == 32'd0, "R10 reset status", r, 0);
    rd_reg(3'd0, r); chk(r == 32'd0, "R5 reset control", r, 0);
    chk({irq_o, lock_o, rd_req, wr_req} == 4'b0, "R8 reset outputs", {irq_o, lock_o, rd_req, wr_req}, 0);

    for (int v = 0; v < 6; v++) begin
      logic [11:0] ctl;
      logic [7:0] s, d, n, sp, dp;
      int sz, bad, first;
      ctl = VEC[v][35:24]; s = VEC[v][23:16]; d = VEC[v][15:8]; n = VEC[v][7:0];
      fill_mem(8'(v + 3));
      sz = 1 << ctl[2:1];
      sp = s; dp = d;
      for (int k = 0; k < int'(n); k++) begin
        logic [7:0] tmp [4];
        for (int b = 0; b < sz; b++) tmp[b] = exp_mem[8'(sp + 8'(b))];
        for (int b = 0; b < sz; b++) exp_mem[8'(dp + 8'(b))] = tmp[b];
        if (!ctl[3]) sp = ctl[5] ? 8'(sp - 8'(sz)) : 8'(sp + 8'(sz));
        dp = ctl[6] ? 8'(dp - 8'(sz)) : 8'(dp + 8'(sz));
      end
      exp_lock = ctl[4];
      lock_bad = 0; order_bad = 0;
      wr_reg(3'd1, 32'(s));
      wr_reg(3'd2, 32'(d));
      wr_reg(3'd3, 32'(n));
      wr_reg(3'd0, 32'(ctl));
      rd_reg(3'd0, r); chk(r[0] == 1'b1, "R5 start reads 1 while running", r, 1);
      rd_reg(3'd4, r); chk(r[4] == 1'b1, "R5 busy while running", r, 32'h10);
      wr_reg(3'd1, 32'(~s));
      for (int t = 0; t < 2000; t++) begin
        rd_reg(3'd4, r);
        if (!r[4]) break;
        @(negedge clk);
      end
      rd_reg(3'd4, r); chk(r[4] == 1'b0 && r[0] == 1'b1, "R10 done set at end", r, 1);
      chk(irq_o == 1'b1, "R10 irq pending", irq_o, 1);
      rd_reg(3'd0, r); chk(r[0] == 1'b0, "R5 start cleared", r, 0);
      rd_reg(3'd1, r); chk(r[7:0] == s, "R12 source write ignored while busy", r, s);
      bad = 0; first = 0;
      for (int i = 0; i < 256; i++)
        if (mem[i] !== exp_mem[i]) begin
          if (bad == 0) first = i;
          bad++;
        end
      chk(bad == 0, "R9 R1 R7 R11 copied bytes", 32'(mem[first]), 32'(exp_mem[first]));
      chk(lock_bad == 0, "R8 lock during run", lock_bad, 0);
      chk(order_bad == 0, "R9 read then write order", order_bad, 0);
      wr_reg(3'd4, 32'h1);
      chk(irq_o == 1'b0, "R10 done cleared by write 1", irq_o, 0);
    end

    // R2 source alignment flag
    wr_reg(3'd1, 32'h02); wr_reg(3'd2, 32'h80);
    wr_reg(3'd0, 32'h004); rd_reg(3'd4, r); chk(r[2] == 1'b1 && r[3] == 1'b0, "R2 word src 0x02 flagged", r, 4);
    wr_reg(3'd0, 32'h002); rd_reg(3'd4, r); chk(r[2] == 1'b0, "R2 half src 0x02 aligned", r, 0);
    wr_reg(3'd1, 32'h03); rd_reg(3'd4, r); chk(r[2] == 1'b1, "R2 half src 0x03 flagged", r, 4);
    wr_reg(3'd0, 32'h000); rd_reg(3'd4, r); chk(r[2] == 1'b0, "R2 byte never flagged", r, 0);
    wr_reg(3'd0, 32'h024); rd_reg(3'd4, r); chk(r[2] == 1'b0, "R2 waived when source descends", r, 0);
    // R3 destination alignment flag
    wr_reg(3'd1, 32'h00); wr_reg(3'd2, 32'h81);
    wr_reg(3'd0, 32'h002); rd_reg(3'd4, r); chk(r[3] == 1'b1 && r[2] == 1'b0, "R3 half dst 0x81 flagged", r, 8);
    wr_reg(3'd0, 32'h042); rd_reg(3'd4, r); chk(r[3] == 1'b0, "R3 waived when destination descends", r, 0);

    // R4 refused start
    fill_mem(8'd50);
    wr_reg(3'd1, 32'h02); wr_reg(3'd2, 32'h80); wr_reg(3'd3, 32'd3);
    req_cnt = 0;
    wr_reg(3'd0, 32'h005);
    repeat (4) @(negedge clk);
    rd_reg(3'd4, r); chk(r[1] == 1'b1 && r[4] == 1'b0 && r[0] == 1'b0, "R4 misaligned start refused", r, 2);
    chk(req_cnt == 0, "R4 no bus request", req_cnt, 0);
    wr_reg(3'd4, 32'h2); rd_reg(3'd4, r); chk(r[1] == 1'b0, "R4 error cleared by write 1", r, 0);

    // R1 reserved width
    wr_reg(3'd1, 32'h00);
    req_cnt = 0;
    wr_reg(3'd0, 32'h007);
    repeat (4) @(negedge clk);
    rd_reg(3'd4, r); chk(r[1] == 1'b1 && r[4] == 1'b0, "R1 width 11 refused", r, 2);
    chk(req_cnt == 0, "R1 no bus request on width 11", req_cnt, 0);
    wr_reg(3'd4, 32'h2);

    // R6 hardware mode ignores start
    req_cnt = 0;
    wr_reg(3'd0, 32'h105);
    repeat (4) @(negedge clk);
    rd_reg(3'd4, r); chk(r[4] == 1'b0 && r[1:0] == 2'b00, "R6 mode 10 ignores start", r, 0);
    rd_reg(3'd0, r); chk(r[0] == 1'b0, "R6 start reads 0 in mode 10", r, 0);
    chk(req_cnt == 0, "R6 no bus request", req_cnt, 0);

    // R13 zero count
    wr_reg(3'd3, 32'd0);
    req_cnt = 0;
    wr_reg(3'd0, 32'h005);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R13 zero count sets done", irq_o, 1);
    chk(req_cnt == 0, "R13 zero count makes no request", req_cnt, 0);
    rd_reg(3'd0, r); chk(r[0] == 1'b0, "R13 start not left set", r, 0);
    wr_reg(3'd4, 32'h1);
    chk(irq_o == 1'b0, "R10 done cleared", irq_o, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule